// File: doc/BRIEF.md
# Hexadecimal Memory Image Stream Loader

This block turns a textual hexadecimal memory image, presented as ASCII bytes on a valid/ready input, into write cycles for a 2048-word by 14-bit RAM. It drives the RAM's write port directly as address, data and a write strobe. A system uses it to fill a RAM from a text image that arrives over any byte channel, such as a debug link or a boot stream, with no simulator file loading.

The parser accepts data words written as bare hex digits. It also accepts address directives that start with `@`, both comment styles, and any whitespace between tokens. Underscores inside numbers are skipped. The unknown digits `x` and `z` are loaded as zero and raise a flag. A reserved end-of-stream byte (0x04 by default) ends the load. Malformed text raises a sticky error flag, and the parser then resumes at the next whitespace.

Top module: `hex_image_loader`

## Requirements
- R1: After reset, `in_ready` is 1, `wr_en` is 0, and `done`, `err` and `unk` are all 0.
- R2: A run of hex digits (0-9, A-F, a-f, any mix of case) with no prefix forms one data word. Words are written to consecutive addresses, starting at address 0.
- R3: Any of space (0x20), tab (0x09), LF (0x0A), VT (0x0B), FF (0x0C) or CR (0x0D) ends a token and separates words.
- R4: A word is written in the single cycle after its terminating byte (whitespace, `/` or end-of-stream) is accepted. `wr_en` is high for exactly that cycle, and `in_ready` is 0 during it.
- R5: Text from `//` up to the next LF is ignored.
- R6: Text from `/*` through the next `*/` is ignored. An end-of-stream byte inside such a comment sets `err`, and the load still completes.
- R7: `@` followed by hex digits sets the address of the next word, and later words count up from there. A directive causes no write, and skipped addresses get no write.
- R8: An underscore inside a data word or an address directive is ignored.
- R9: A digit `x`, `X`, `z` or `Z` counts as the value 0 and sets `unk`.
- R10: A word whose value needs more than 14 bits sets `err` and is not written. Its address slot is still used, so the next word goes to the following address.
- R11: A write to an address above 2047, reached either by a directive or by counting past the last address, is suppressed and sets `err`.
- R12: Any character that is not legal where it appears sets `err`. The rest of that token, up to the next whitespace, is discarded and is not written.
- R13: The end-of-stream byte 0x04 commits any pending word. `done` then goes to 1 and stays there, and `in_ready` stays 0 from then on.
- R14: Once `err` or `unk` goes high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input byte is offered |
| in_byte | input | 8 | ASCII input byte |
| in_ready | output | 1 | The parser accepts the offered byte on this edge |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 11 | RAM write address |
| wr_data | output | 14 | RAM write data |
| done | output | 1 | End-of-stream reached |
| err | output | 1 | Sticky malformed-input flag |
| unk | output | 1 | Sticky unknown-digit flag |

## Verification
The main sweep loads every one of the 2048 addresses with a computed value. It rotates through upper case and lower case digits, all six whitespace separators, numbers with and without leading zeros, and numbers with embedded underscores. This separates bugs in digit decoding from bugs in address stepping. One further word then probes the end of the address space. Short hand-built streams mix directives, both comment styles, a word ended by `/`, and unknown digits. Oversized values, stray characters, and end-of-stream arriving mid-word, inside a block comment or after a line comment then show whether a suppressed write still advances the address and whether the parser recovers at the right byte.

// File: rtl/hexload_pkg.sv
package hexload_pkg;

    typedef enum logic [3:0] {
        K_DIGIT,
        K_UNK,
        K_UNDER,
        K_SPACE,
        K_SLASH,
        K_STAR,
        K_AT,
        K_EOS,
        K_OTHER
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       newline;
        logic [3:0] value;
    } chr_t;

    typedef enum logic [3:0] {
        ST_GAP,
        ST_WORD,
        ST_ADDR,
        ST_SLASH,
        ST_LINE,
        ST_BLOCK,
        ST_BSTAR,
        ST_SKIP,
        ST_WRITE,
        ST_DONE
    } state_e;

endpackage

// File: rtl/hexload_classify.sv
module hexload_classify
    import hexload_pkg::*;
#(
    parameter logic [7:0] EOS_CODE = 8'h04
) (
    input  logic [7:0] in_byte,
    output chr_t       chr
);

    always_comb begin
        chr         = '0;
        chr.kind    = K_OTHER;
        chr.newline = (in_byte == 8'h0A);
        if (in_byte == EOS_CODE) begin
            chr.kind = K_EOS;
        end else if (in_byte >= 8'h30 && in_byte <= 8'h39) begin
            chr.kind  = K_DIGIT;
            chr.value = in_byte[3:0];
        end else if ((in_byte >= 8'h41 && in_byte <= 8'h46) ||
                     (in_byte >= 8'h61 && in_byte <= 8'h66)) begin
            chr.kind  = K_DIGIT;
            chr.value = in_byte[3:0] + 4'd9;
        end else if (in_byte == 8'h78 || in_byte == 8'h58 ||
                     in_byte == 8'h7A || in_byte == 8'h5A) begin
            chr.kind = K_UNK;
        end else if (in_byte == 8'h5F) begin
            chr.kind = K_UNDER;
        end else if (in_byte == 8'h20 || (in_byte >= 8'h09 && in_byte <= 8'h0D)) begin
            chr.kind = K_SPACE;
        end else if (in_byte == 8'h2F) begin
            chr.kind = K_SLASH;
        end else if (in_byte == 8'h2A) begin
            chr.kind = K_STAR;
        end else if (in_byte == 8'h40) begin
            chr.kind = K_AT;
        end
    end

endmodule

// File: rtl/hexload_core.sv
module hexload_core
    import hexload_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  chr_t              chr,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err,
    output logic              unk
);

    localparam int ACC_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

    typedef struct packed {
        state_e            state;
        state_e            ret;
        logic [ACC_W-1:0]  acc;
        logic              acc_ovf;
        logic              have_dig;
        logic [ADDR_W-1:0] addr;
        logic              addr_ovf;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              err;
        logic              unk;
    } regs_t;

    regs_t q, d;

    logic              take;
    logic [ACC_W+3:0]  wide;
    logic              hi_data;
    logic              hi_addr;
    logic [ADDR_W:0]   nxt_addr;
    state_e            follow;
    logic              word_ok;

    assign in_ready = (q.state != ST_WRITE) && (q.state != ST_DONE);
    assign take     = in_valid && in_ready;
    assign wide     = {q.acc, chr.value};
    assign hi_data  = |wide[ACC_W+3:DATA_W];
    assign hi_addr  = |wide[ACC_W+3:ADDR_W];
    assign nxt_addr = {1'b0, q.addr} + (ADDR_W+1)'(1);
    assign word_ok  = !q.acc_ovf && !q.addr_ovf;

    always_comb begin
        case (chr.kind)
            K_SLASH: follow = ST_SLASH;
            K_EOS:   follow = ST_DONE;
            default: follow = ST_GAP;
        endcase
    end

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (q.state == ST_WRITE) begin
            d.state = q.ret;
        end else if (take) begin
            case (q.state)
                ST_GAP: begin
                    case (chr.kind)
                        K_DIGIT, K_UNK: begin
                            d.state   = ST_WORD;
                            d.acc     = ACC_W'(chr.value);
                            d.acc_ovf = 1'b0;
                            d.unk     = q.unk | (chr.kind == K_UNK);
                        end
                        K_AT: begin
                            d.state    = ST_ADDR;
                            d.acc      = '0;
                            d.acc_ovf  = 1'b0;
                            d.have_dig = 1'b0;
                        end
                        K_SPACE: ;
                        K_SLASH: d.state = ST_SLASH;
                        K_EOS:   d.state = ST_DONE;
                        default: begin
                            d.err   = 1'b1;
                            d.state = ST_SKIP;
                        end
                    endcase
                end
                ST_WORD, ST_ADDR: begin
                    case (chr.kind)
                        K_DIGIT, K_UNK: begin
                            d.acc      = wide[ACC_W-1:0];
                            d.acc_ovf  = q.acc_ovf |
                                         ((q.state == ST_WORD) ? hi_data : hi_addr);
                            d.have_dig = 1'b1;
                            d.unk      = q.unk | (chr.kind == K_UNK);
                        end
                        K_UNDER: ;
                        K_SPACE, K_SLASH, K_EOS: begin
                            if (q.state == ST_WORD) begin
                                d.wr_en    = word_ok;
                                d.wr_addr  = q.addr;
                                d.wr_data  = q.acc[DATA_W-1:0];
                                d.err      = q.err | !word_ok;
                                d.addr     = nxt_addr[ADDR_W-1:0];
                                d.addr_ovf = q.addr_ovf | nxt_addr[ADDR_W];
                                d.ret      = follow;
                                d.state    = ST_WRITE;
                            end else begin
                                if (!q.have_dig) begin
                                    d.err = 1'b1;
                                end else begin
                                    d.addr     = q.acc[ADDR_W-1:0];
                                    d.addr_ovf = q.acc_ovf;
                                end
                                d.state = follow;
                            end
                        end
                        default: begin
                            d.err   = 1'b1;
                            d.state = ST_SKIP;
                        end
                    endcase
                end
                ST_SLASH: begin
                    case (chr.kind)
                        K_SLASH: d.state = ST_LINE;
                        K_STAR:  d.state = ST_BLOCK;
                        K_SPACE: begin d.err = 1'b1; d.state = ST_GAP;  end
                        K_EOS:   begin d.err = 1'b1; d.state = ST_DONE; end
                        default: begin d.err = 1'b1; d.state = ST_SKIP; end
                    endcase
                end
                ST_LINE: begin
                    if (chr.newline)             d.state = ST_GAP;
                    else if (chr.kind == K_EOS)  d.state = ST_DONE;
                end
                ST_BLOCK: begin
                    if (chr.kind == K_STAR) begin
                        d.state = ST_BSTAR;
                    end else if (chr.kind == K_EOS) begin
                        d.err   = 1'b1;
                        d.state = ST_DONE;
                    end
                end
                ST_BSTAR: begin
                    case (chr.kind)
                        K_SLASH: d.state = ST_GAP;
                        K_STAR:  d.state = ST_BSTAR;
                        K_EOS:   begin d.err = 1'b1; d.state = ST_DONE; end
                        default: d.state = ST_BLOCK;
                    endcase
                end
                ST_SKIP: begin
                    if (chr.kind == K_SPACE)     d.state = ST_GAP;
                    else if (chr.kind == K_EOS)  d.state = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_GAP;
            q.ret   <= ST_GAP;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign done    = (q.state == ST_DONE);
    assign err     = q.err;
    assign unk     = q.unk;

endmodule

// File: rtl/hex_image_loader.sv
module hex_image_loader
    import hexload_pkg::*;
#(
    parameter int         DATA_W   = 14,
    parameter int         ADDR_W   = 11,
    parameter logic [7:0] EOS_CODE = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              err,
    output logic              unk
);

    chr_t chr;

    hexload_classify #(.EOS_CODE(EOS_CODE)) u_class (
        .in_byte (in_byte),
        .chr     (chr)
    );

    hexload_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .chr      (chr),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .done     (done),
        .err      (err),
        .unk      (unk)
    );

endmodule

// File: rtl/hexload_checker.sv
module hexload_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic wr_en,
    input logic done,
    input logic err,
    input logic unk
);

    p_write_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);

    p_write_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_done_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_done_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready && !wr_en);

    p_err_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_unk_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        unk |=> unk);

endmodule

bind hex_image_loader hexload_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .done     (done),
    .err      (err),
    .unk      (unk)
);

// File: tb/sim_hex_image_loader.sv
module sim_hex_image_loader;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, wr_en, done, err, unk;
    logic [10:0] wr_addr;
    logic [13:0] wr_data;

    int checks = 0;
    int errors = 0;

    int cap_addr [4096];
    int cap_data [4096];
    int cap_n = 0;
    int exp_addr [4096];
    int exp_data [4096];
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hex_image_loader u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err), .unk(unk)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en && cap_n < 4096) begin
            cap_addr[cap_n] = int'(wr_addr);
            cap_data[cap_n] = int'(wr_data);
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cap_n = 0;
        exp_n = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic expect_wr(input int a, input int v);
        exp_addr[exp_n] = a;
        exp_data[exp_n] = v;
        exp_n++;
    endtask

    task automatic compare_writes(input string req);
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_addr[i] == exp_addr[i], req, cap_addr[i], exp_addr[i]);
            chk(cap_data[i] == exp_data[i], req, cap_data[i], exp_data[i]);
        end
    endtask

    function automatic logic [7:0] hexch(input int dig, input bit upper);
        if (dig < 10) return 8'(8'h30 + dig);
        return 8'((upper ? 8'h41 : 8'h61) + dig - 10);
    endfunction

    task automatic send_word(input int v, input bit upper, input bit strip,
                             input bit under, input logic [7:0] sep);
        bit started = 1'b0;
        int emitted = 0;
        for (int k = 3; k >= 0; k--) begin
            int dig = (v >> (4 * k)) & 15;
            if (strip && !started && dig == 0 && k != 0) continue;
            started = 1'b1;
            send_byte(hexch(dig, upper));
            emitted++;
            if (under && emitted == 1) send_byte(8'h5F);
        end
        send_byte(sep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] seps [6];
        seps = '{8'h20, 8'h09, 8'h0A, 8'h0D, 8'h0B, 8'h0C};

        // R1 reset state
        do_reset();
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
        chk({done, err, unk} == 3'b000, "R1 flags", {done, err, unk}, 0);

        // R2 R3 R8: sweep of every address with mixed formatting
        for (int i = 0; i < DEPTH; i++) begin
            int v = (i * 2731 + 5) & 16'h3FFF;
            send_word(v, (i % 2) == 0, (i % 3) == 0, (i % 5) == 0, seps[i % 6]);
            if (i == 0) begin
                chk(wr_en == 1'b1, "R4 strobe after separator", wr_en, 1);
                chk(in_ready == 1'b0, "R4 stall during write", in_ready, 0);
            end
            expect_wr(i, v);
        end
        @(negedge clk);
        chk(err == 1'b0, "R2/R3/R8 no error in sweep", err, 0);
        compare_writes("R2/R3/R8 sweep");
        // R11 counting past the last address
        send_str("1 ");
        @(negedge clk);
        chk(err == 1'b1, "R11 wrap past end flags error", err, 1);
        chk(cap_n == DEPTH, "R11 write suppressed past end", cap_n, DEPTH);
        send_byte(8'h04);
        @(negedge clk);
        chk(done == 1'b1, "R13 done after end byte", done, 1);
        chk(in_ready == 1'b0, "R13 not ready after done", in_ready, 0);

        // R5 R6 R7: directives and comments
        do_reset();
        send_str("@10 // note 55\n 1a2B /* 77 @3 */ 3/*c*/4 @7_ff 5 ");
        @(negedge clk);
        chk(err == 1'b0, "R5/R6/R7 clean stream", err, 0);
        expect_wr(16'h10, 16'h1A2B);
        expect_wr(16'h11, 3);
        expect_wr(16'h12, 4);
        expect_wr(16'h7FF, 5);
        compare_writes("R5/R6/R7 directives and comments");
        send_str("@800 6 ");
        @(negedge clk);
        chk(err == 1'b1, "R11 directive beyond range", err, 1);
        chk(cap_n == 4, "R11 no write beyond range", cap_n, 4);
        send_byte(8'h04);
        @(negedge clk);
        chk(done == 1'b1, "R13 done", done, 1);

        // R9 R10: unknown digits and oversized words
        do_reset();
        send_str("12x4 Z\n");
        @(negedge clk);
        chk(unk == 1'b1, "R9 unknown digit flag", unk, 1);
        chk(err == 1'b0, "R9 no error for x/z", err, 0);
        send_str("4000 7 ");
        @(negedge clk);
        chk(err == 1'b1, "R10 oversized word flags error", err, 1);
        expect_wr(0, 16'h1204);
        expect_wr(1, 0);
        expect_wr(3, 7);
        compare_writes("R9/R10 unknown and oversized");
        chk(unk == 1'b1, "R14 unk sticky", unk, 1);

        // R12 R14: stray characters
        do_reset();
        send_str("5g7 9 q12 8 ");
        @(negedge clk);
        chk(err == 1'b1, "R12 stray character error", err, 1);
        expect_wr(0, 9);
        expect_wr(1, 8);
        compare_writes("R12 discarded tokens");
        send_str("3 // tail");
        send_byte(8'h04);
        @(negedge clk);
        chk(err == 1'b1, "R14 err sticky", err, 1);
        chk(done == 1'b1, "R13 end inside line comment", done, 1);

        // R6 end byte inside block comment
        do_reset();
        send_str("1 /* abc");
        send_byte(8'h04);
        @(negedge clk);
        chk(err == 1'b1, "R6 end inside block comment", err, 1);
        chk(done == 1'b1, "R6 load still completes", done, 1);
        expect_wr(0, 1);
        compare_writes("R6 write before comment");

        // R13 end byte commits a pending word
        do_reset();
        send_str("2a");
        send_byte(8'h04);
        chk(wr_en == 1'b1 && done == 1'b0, "R13 pending word written first",
            {wr_en, done}, 2'b10);
        @(negedge clk);
        chk(done == 1'b1 && in_ready == 1'b0, "R13 done after commit",
            {done, in_ready}, 2'b10);
        expect_wr(0, 16'h2A);
        compare_writes("R13 pending word");
        chk(err == 1'b0, "R13 clean end", err, 0);

        finish_run();
    end

endmodule